// File: doc/BRIEF.md
# Low-Power Mode Controller with Core Retention

This block is the top-level power-state machine of a wireless chip. It keeps the chip in one of four power levels: fully on, dozing, deep-sleeping with the digital core unpowered, or fully off. For each level it drives a resource request mask to the regulator sequencer. It also runs the ordered handshakes that surround a digital-core power cycle: a state save into always-on retention storage, isolation of the core's outputs, removal of core power, and the reverse on wake-up.

Software asks for a lower power level while the chip is awake. Hardware events bring it back. A wake timer or an external interrupt ends a doze. Deep sleep additionally ends on a host resume indication from the SDIO host interface. The fully-off level ignores every internal event and is left only when external logic switches the regulators back on.

Top module: `lpm_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `cur_state` is 0, `req_mask` equals the full mask, `iso_en` and `core_pwr_off` are 0, and both strobes are 0.
- R2: `cur_state` reports Active = 0, Doze = 1, Deep-sleep = 2 (including its entry and wake sequences) and Power-down = 3 (including the cold restart). `req_mask` is the full mask while awake and in every transitional step, the doze mask in Doze, the deep mask while the core is off, and all zeros in Power-down.
- R3: `sw_req_valid` with `sw_req_mode` 1, 2 or 3 starts the move to Doze, Deep-sleep or Power-down. This happens only in Active. Mode 0, and any request made in another state, has no effect.
- R4: In Doze, `wake_timer` or `ext_irq` switches `req_mask` to the full mask, and the block returns to Active on the first cycle `seq_settled` is high. `host_resume` is ignored in Doze.
- R5: Deep-sleep entry pulses `save_strobe` for exactly one cycle, with the core powered and not isolated. The block then waits for `save_done`, raises `iso_en`, and asserts `core_pwr_off` one cycle later.
- R6: While the core is off, any one of `wake_timer`, `ext_irq` or `host_resume` starts the wake sequence.
- R7: The wake sequence first drops `core_pwr_off` with `iso_en` still held. It then waits for `seq_settled` and pulses `restore_strobe` for one cycle. After `restore_done` it releases `iso_en` and reports Active.
- R8: A wake event that arrives while the entry sequence is still running (waiting for `save_done`, or the isolation cycle) is remembered. The core then stays off for exactly one cycle before the wake sequence starts.
- R9: Power-down holds `iso_en` = 1 and `core_pwr_off` = 1. It ignores all three wake sources and software requests, and leaves only on `reg_enable`. The core is then repowered and the block becomes Active once `seq_settled` is high, with no `restore_strobe`.
- R10: `core_pwr_off` is never high while `iso_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-power clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_req_valid | input | 1 | Software mode request strobe |
| sw_req_mode | input | 2 | Requested level: 1 doze, 2 deep-sleep, 3 power-down |
| wake_timer | input | 1 | Wake timer expiry |
| ext_irq | input | 1 | External interrupt |
| host_resume | input | 1 | Host resume indication from the SDIO host interface |
| reg_enable | input | 1 | External regulator re-enable |
| seq_settled | input | 1 | Sequencer reports requested resources are up |
| save_done | input | 1 | Retention save finished |
| restore_done | input | 1 | Retention restore finished |
| req_mask | output | NRES | Resource request mask to the sequencer |
| save_strobe | output | 1 | One-cycle retention save request |
| restore_strobe | output | 1 | One-cycle retention restore request |
| iso_en | output | 1 | Core output isolation |
| core_pwr_off | output | 1 | Digital core power switch off |
| cur_state | output | 2 | Current power level code |

## Verification
The bench walks every wake source through a full deep-sleep cycle. It also injects each source early, in both phases of the entry sequence. A design that forgot an early event would leave the core off indefinitely. One that dropped isolation too soon would release it with the core unpowered. The bench sends every wake source and software request into Power-down, where a leaky design would wake without its regulators. It checks that `host_resume` does not end a doze, and that a cold restart never fires a restore that would load stale retention data.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [3:0] {
        ST_ACTIVE,
        ST_DOZE,
        ST_DOZE_WAKE,
        ST_DS_SAVE,
        ST_DS_ISO,
        ST_DS_OFF,
        ST_DS_PWRUP,
        ST_DS_RESTORE,
        ST_PDOWN,
        ST_COLD
    } fsm_state_e;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_DOZE   = 2'd1,
        MODE_DEEP   = 2'd2,
        MODE_PDOWN  = 2'd3
    } pwr_mode_e;

    typedef enum logic [1:0] {
        LVL_FULL,
        LVL_DOZE,
        LVL_DEEP,
        LVL_NONE
    } mask_lvl_e;

    typedef struct packed {
        fsm_state_e state;
        logic       save_stb;
        logic       restore_stb;
    } fsm_regs_t;

endpackage

// File: rtl/lpm_wake_merge.sv
module lpm_wake_merge #(
    parameter int              NSRC     = 3,
    parameter logic [NSRC-1:0] DOZE_SEL = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            capture,
    input  logic            clear,
    output logic            deep_wake,
    output logic            doze_wake
);

    logic pending_d, pending_q;

    always_comb begin
        pending_d = pending_q;
        if (clear) begin
            pending_d = 1'b0;
        end else if (capture && (|src)) begin
            pending_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= pending_d;
        end
    end

    assign deep_wake = (|src) | pending_q;
    assign doze_wake = |(src & DOZE_SEL);

    // An event seen during the entry sequence must still be visible next cycle
    p_early_wake_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clear && (|src)) |=> deep_wake);

endmodule

// File: rtl/lpm_mask_map.sv
module lpm_mask_map
    import lpm_pkg::*;
#(
    parameter int              NRES      = 8,
    parameter logic [NRES-1:0] MASK_FULL = '1,
    parameter logic [NRES-1:0] MASK_DOZE = '0,
    parameter logic [NRES-1:0] MASK_DEEP = '0
) (
    input  mask_lvl_e       lvl,
    output logic [NRES-1:0] mask
);

    always_comb begin
        unique case (lvl)
            LVL_FULL: mask = MASK_FULL;
            LVL_DOZE: mask = MASK_DOZE;
            LVL_DEEP: mask = MASK_DEEP;
            default:  mask = '0;
        endcase
    end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_req_valid,
    input  logic [1:0] sw_req_mode,
    input  logic      deep_wake,
    input  logic      doze_wake,
    input  logic      reg_enable,
    input  logic      seq_settled,
    input  logic      save_done,
    input  logic      restore_done,
    output mask_lvl_e mask_lvl,
    output logic [1:0] cur_state,
    output logic      save_strobe,
    output logic      restore_strobe,
    output logic      iso_en,
    output logic      core_pwr_off,
    output logic      wake_capture,
    output logic      wake_clear
);

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d             = r_q;
        r_d.save_stb    = 1'b0;
        r_d.restore_stb = 1'b0;
        unique case (r_q.state)
            ST_ACTIVE: begin
                if (sw_req_valid) begin
                    unique case (pwr_mode_e'(sw_req_mode))
                        MODE_DOZE:  r_d.state = ST_DOZE;
                        MODE_DEEP: begin
                            r_d.state    = ST_DS_SAVE;
                            r_d.save_stb = 1'b1;
                        end
                        MODE_PDOWN: r_d.state = ST_PDOWN;
                        default:    r_d.state = ST_ACTIVE;
                    endcase
                end
            end
            ST_DOZE:       if (doze_wake)    r_d.state = ST_DOZE_WAKE;
            ST_DOZE_WAKE:  if (seq_settled)  r_d.state = ST_ACTIVE;
            ST_DS_SAVE:    if (save_done)    r_d.state = ST_DS_ISO;
            ST_DS_ISO:                       r_d.state = ST_DS_OFF;
            ST_DS_OFF:     if (deep_wake)    r_d.state = ST_DS_PWRUP;
            ST_DS_PWRUP: begin
                if (seq_settled) begin
                    r_d.state       = ST_DS_RESTORE;
                    r_d.restore_stb = 1'b1;
                end
            end
            ST_DS_RESTORE: if (restore_done) r_d.state = ST_ACTIVE;
            ST_PDOWN:      if (reg_enable)   r_d.state = ST_COLD;
            ST_COLD:       if (seq_settled)  r_d.state = ST_ACTIVE;
            default:                         r_d.state = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_ACTIVE, save_stb: 1'b0, restore_stb: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mask_lvl     = LVL_FULL;
        cur_state    = MODE_ACTIVE;
        iso_en       = 1'b0;
        core_pwr_off = 1'b0;
        unique case (r_q.state)
            ST_DOZE: begin
                cur_state = MODE_DOZE;
                mask_lvl  = LVL_DOZE;
            end
            ST_DOZE_WAKE: cur_state = MODE_DOZE;
            ST_DS_SAVE:   cur_state = MODE_DEEP;
            ST_DS_ISO, ST_DS_PWRUP, ST_DS_RESTORE: begin
                cur_state = MODE_DEEP;
                iso_en    = 1'b1;
            end
            ST_DS_OFF: begin
                cur_state    = MODE_DEEP;
                mask_lvl     = LVL_DEEP;
                iso_en       = 1'b1;
                core_pwr_off = 1'b1;
            end
            ST_PDOWN: begin
                cur_state    = MODE_PDOWN;
                mask_lvl     = LVL_NONE;
                iso_en       = 1'b1;
                core_pwr_off = 1'b1;
            end
            ST_COLD: begin
                cur_state = MODE_PDOWN;
                iso_en    = 1'b1;
            end
            default: ;
        endcase
    end

    assign save_strobe    = r_q.save_stb;
    assign restore_strobe = r_q.restore_stb;
    assign wake_capture   = (r_q.state == ST_DS_SAVE) || (r_q.state == ST_DS_ISO);
    assign wake_clear     = (r_q.state == ST_DS_OFF) && deep_wake;

    p_iso_covers_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_pwr_off |-> iso_en);

    p_save_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        save_strobe |=> !save_strobe);

    p_iso_before_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_pwr_off ##1 core_pwr_off && cur_state == MODE_DEEP) |-> $past(iso_en));

    p_restore_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restore_strobe |=> !restore_strobe);

    p_pdown_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PDOWN && !reg_enable) |=> (r_q.state == ST_PDOWN));

    p_restore_after_deep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore_strobe) |-> (cur_state == MODE_DEEP && iso_en));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int              NRES      = 8,
    parameter logic [NRES-1:0] MASK_FULL = 8'hFF,
    parameter logic [NRES-1:0] MASK_DOZE = 8'h03,
    parameter logic [NRES-1:0] MASK_DEEP = 8'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_req_valid,
    input  logic [1:0]      sw_req_mode,
    input  logic            wake_timer,
    input  logic            ext_irq,
    input  logic            host_resume,
    input  logic            reg_enable,
    input  logic            seq_settled,
    input  logic            save_done,
    input  logic            restore_done,
    output logic [NRES-1:0] req_mask,
    output logic            save_strobe,
    output logic            restore_strobe,
    output logic            iso_en,
    output logic            core_pwr_off,
    output logic [1:0]      cur_state
);

    localparam int              NSRC     = 3;
    localparam logic [NSRC-1:0] DOZE_SEL = 3'b011;

    logic [NSRC-1:0] wake_src;
    logic            deep_wake, doze_wake, wake_capture, wake_clear;
    mask_lvl_e       mask_lvl;

    assign wake_src = {host_resume, ext_irq, wake_timer};

    lpm_wake_merge #(
        .NSRC     (NSRC),
        .DOZE_SEL (DOZE_SEL)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (wake_src),
        .capture   (wake_capture),
        .clear     (wake_clear),
        .deep_wake (deep_wake),
        .doze_wake (doze_wake)
    );

    lpm_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_req_valid   (sw_req_valid),
        .sw_req_mode    (sw_req_mode),
        .deep_wake      (deep_wake),
        .doze_wake      (doze_wake),
        .reg_enable     (reg_enable),
        .seq_settled    (seq_settled),
        .save_done      (save_done),
        .restore_done   (restore_done),
        .mask_lvl       (mask_lvl),
        .cur_state      (cur_state),
        .save_strobe    (save_strobe),
        .restore_strobe (restore_strobe),
        .iso_en         (iso_en),
        .core_pwr_off   (core_pwr_off),
        .wake_capture   (wake_capture),
        .wake_clear     (wake_clear)
    );

    lpm_mask_map #(
        .NRES      (NRES),
        .MASK_FULL (MASK_FULL),
        .MASK_DOZE (MASK_DOZE),
        .MASK_DEEP (MASK_DEEP)
    ) u_mask (
        .lvl  (mask_lvl),
        .mask (req_mask)
    );

endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;

    localparam int         NRES = 8;
    localparam logic [7:0] MF   = 8'hFF;
    localparam logic [7:0] MZ   = 8'h03;
    localparam logic [7:0] MD   = 8'h01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_req_valid = 1'b0;
    logic [1:0] sw_req_mode = 2'd0;
    logic wake_timer = 1'b0, ext_irq = 1'b0, host_resume = 1'b0;
    logic reg_enable = 1'b0, seq_settled = 1'b0, save_done = 1'b0, restore_done = 1'b0;
    logic [NRES-1:0] req_mask;
    logic save_strobe, restore_strobe, iso_en, core_pwr_off;
    logic [1:0] cur_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    lpm_ctrl #(
        .NRES(NRES), .MASK_FULL(MF), .MASK_DOZE(MZ), .MASK_DEEP(MD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sw_req_valid(sw_req_valid), .sw_req_mode(sw_req_mode),
        .wake_timer(wake_timer), .ext_irq(ext_irq), .host_resume(host_resume),
        .reg_enable(reg_enable), .seq_settled(seq_settled), .save_done(save_done),
        .restore_done(restore_done), .req_mask(req_mask), .save_strobe(save_strobe),
        .restore_strobe(restore_strobe), .iso_en(iso_en), .core_pwr_off(core_pwr_off),
        .cur_state(cur_state)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Full snapshot: state code, mask, isolation, power-off
    task automatic snap(input string req, input int st, input int m, input int iso, input int off);
        chk(req, "cur_state", cur_state, st);
        chk(req, "req_mask", req_mask, m);
        chk(req, "iso_en", iso_en, iso);
        chk(req, "core_pwr_off", core_pwr_off, off);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_src(input int s, input logic v);
        case (s)
            0: wake_timer = v;
            1: ext_irq = v;
            default: host_resume = v;
        endcase
    endtask

    task automatic request(input logic [1:0] mode);
        sw_req_valid = 1'b1;
        sw_req_mode  = mode;
        tick();
        sw_req_valid = 1'b0;
        sw_req_mode  = 2'd0;
    endtask

    // From powered-up-isolated step to Active via restore handshake
    task automatic finish_wake();
        tick();
        chk("R7", "no restore before settled", restore_strobe, 0);
        seq_settled = 1'b1;
        tick();
        seq_settled = 1'b0;
        chk("R7", "restore_strobe", restore_strobe, 1);
        snap("R7", 2, MF, 1, 0);
        tick();
        chk("R7", "restore pulse width", restore_strobe, 0);
        chk("R7", "iso held until done", iso_en, 1);
        restore_done = 1'b1;
        tick();
        restore_done = 1'b0;
        snap("R7", 0, MF, 0, 0);
    endtask

    initial begin
        #(20 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        // R1: reset state
        snap("R1", 0, MF, 0, 0);
        chk("R1", "save_strobe", save_strobe, 0);
        chk("R1", "restore_strobe", restore_strobe, 0);

        // R3: mode 0 and wake events in Active do nothing
        request(2'd0);
        snap("R3", 0, MF, 0, 0);
        for (int s = 0; s < 3; s++) begin
            set_src(s, 1'b1);
            tick();
            set_src(s, 1'b0);
            snap("R3", 0, MF, 0, 0);
        end

        // R4: doze, host resume ignored, timer or irq wakes
        for (int s = 0; s < 2; s++) begin
            request(2'd1);
            snap("R2", 1, MZ, 0, 0);
            host_resume = 1'b1;
            tick();
            host_resume = 1'b0;
            tick();
            snap("R4", 1, MZ, 0, 0);
            request(2'd3);
            snap("R3", 1, MZ, 0, 0);
            set_src(s, 1'b1);
            tick();
            set_src(s, 1'b0);
            snap("R4", 1, MF, 0, 0);
            tick();
            snap("R4", 1, MF, 0, 0);
            seq_settled = 1'b1;
            tick();
            seq_settled = 1'b0;
            snap("R4", 0, MF, 0, 0);
        end

        // R5 R6 R7: full deep-sleep cycle for each wake source
        for (int s = 0; s < 3; s++) begin
            request(2'd2);
            chk("R5", "save_strobe", save_strobe, 1);
            snap("R5", 2, MF, 0, 0);
            tick();
            chk("R5", "save pulse width", save_strobe, 0);
            snap("R5", 2, MF, 0, 0);
            save_done = 1'b1;
            tick();
            save_done = 1'b0;
            snap("R5", 2, MF, 1, 0);
            tick();
            snap("R2", 2, MD, 1, 1);
            for (int k = 0; k < 3; k++) tick();
            snap("R6", 2, MD, 1, 1);
            set_src(s, 1'b1);
            tick();
            set_src(s, 1'b0);
            snap("R6", 2, MF, 1, 0);
            finish_wake();
        end

        // R8: early wake in save wait (phase 0) or isolation cycle (phase 1)
        for (int s = 0; s < 3; s++) begin
            for (int ph = 0; ph < 2; ph++) begin
                request(2'd2);
                if (ph == 0) begin
                    set_src(s, 1'b1);
                    tick();
                    set_src(s, 1'b0);
                    save_done = 1'b1;
                    tick();
                    save_done = 1'b0;
                end else begin
                    save_done = 1'b1;
                    tick();
                    save_done = 1'b0;
                    set_src(s, 1'b1);
                    tick();
                    set_src(s, 1'b0);
                end
                if (ph == 0) tick();
                snap("R8", 2, MD, 1, 1);
                tick();
                snap("R8", 2, MF, 1, 0);
                finish_wake();
            end
        end

        // R9: power-down, everything internal ignored, cold restart
        request(2'd3);
        snap("R9", 3, 0, 1, 1);
        for (int s = 0; s < 3; s++) begin
            set_src(s, 1'b1);
            seq_settled = 1'b1;
            tick();
            set_src(s, 1'b0);
            seq_settled = 1'b0;
            snap("R9", 3, 0, 1, 1);
        end
        request(2'd0);
        snap("R9", 3, 0, 1, 1);
        reg_enable = 1'b1;
        tick();
        reg_enable = 1'b0;
        snap("R9", 3, MF, 1, 0);
        tick();
        snap("R9", 3, MF, 1, 0);
        seq_settled = 1'b1;
        tick();
        seq_settled = 1'b0;
        snap("R9", 0, MF, 0, 0);
        chk("R9", "no restore on cold start", restore_strobe, 0);
        chk("R10", "off implies isolation", core_pwr_off & ~iso_en, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // R10: sampled every cycle away from the edge
    always @(negedge clk) begin
        if (rst_n && !done && core_pwr_off && !iso_en) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 iso_en: actual 0 expected 1");
        end
    end

endmodule